// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block places incoming Ethernet frames into host-visible receive buffers. The buffers are described by a ring of descriptors held in a small internal descriptor store. Each descriptor holds a 16-bit status word, a 16-bit length and a 32-bit buffer address. Frame bytes arrive on a byte stream that carries start, end and error markers. Every accepted byte goes out on a byte-wide memory write port, at the descriptor's buffer address plus the byte's offset in the frame. When the frame ends, the block writes the length and status back into the descriptor.

Ownership is carried by the status word's empty bit. The host sets it to hand a descriptor to the block, and the block clears it after a frame has been stored. A wrap bit marks the last descriptor and sends the ring back to its first entry. Reception runs only while polling is armed. The host arms polling through the activation register, or by handing back a descriptor. Polling stops when a frame meets a descriptor the host still owns, and that frame is dropped and counted.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, the activation, base and overrun registers read 0, every descriptor word reads 0 and the memory write port stays idle.
- R2: With host_addr bit HAW-1 clear (HAW = log2(NDESC)+4), byte address n*8 selects descriptor n. Offset +0 is {status[15:0], length[15:0]} and offset +4 is the buffer address. Writes are read back unchanged.
- R3: With host_addr bit HAW-1 set, offset 0 is the activation register. A write with bit 24 set arms polling, and a read returns the poll-active flag in bit 24. A write with bit 24 clear has no effect.
- R4: A frame is accepted when its start byte arrives while polling is armed and the current descriptor has status bit 15 (empty) set. Byte k of the frame appears on the memory port one cycle after it is presented, at buffer address + k.
- R5: In the cycle after the last byte, the descriptor reads back with status bit 15 clear, status bit 13 (wrap) and bits 14..6 kept, and length equal to the number of bytes received, including the 4-byte check sequence.
- R6: After a frame is stored, the ring moves to the next descriptor. If the used descriptor had status bit 13 set, the ring returns to ring index 0.
- R7: A frame whose start meets polling disarmed, or a current descriptor without the empty bit, is dropped with no memory write. The overrun count (control offset 8) goes up by 1 and polling is disarmed. Bytes up to that frame's end are ignored.
- R8: A host write to a descriptor's offset +0 with data bit 31 set (status empty) arms polling. A write to offset +4 does not.
- R9: A frame longer than FRAME_MAX bytes sets status bit 5. Only its first BUF_MAX bytes are written, and length saturates at BUF_MAX. A frame of exactly FRAME_MAX bytes leaves bit 5 clear.
- R10: If any byte of an accepted frame carries in_err, status bit 1 is set. The other bits of status bits 5..0 are written as 0.
- R11: A write to control offset 4 makes descriptor wdata[log2(NDESC)+2:3] the first entry of the ring and resets the ring index to 0. A read of that offset returns the entry number times 8.
- R12: Bytes that arrive outside a frame, without a start marker, cause no memory write and no descriptor change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | log2(NDESC)+4 | Host byte address (descriptors or control) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Receive error marker on this byte |
| in_data | input | 8 | Frame byte |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 32 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory byte |

## Verification
The bench builds the block with NDESC=4, BUF_MAX=20 and FRAME_MAX=18. With these values, truncation and the long-frame flag can be reached with frames of 19 to 25 bytes. A full trip around the ring takes four frames, and a ring that does not start at entry 0 can be tested by moving the base to entry 2. With four entries the power-of-two index path is used. The behavioural model follows ownership, drops and the overrun count across those wraps, and checks the memory port on every clock.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int LEN_W    = 16;
   localparam int ST_EMPTY = 15;
   localparam int ST_WRAP  = 13;
   localparam int ST_LONG  = 5;
   localparam int ST_RXERR = 1;
   localparam int ERR_BITS = 6;
   localparam int ACT_BIT  = 24;

   typedef struct packed {
      logic [LEN_W-1:0] st;
      logic [LEN_W-1:0] len;
      logic [31:0]      buf_addr;
   } desc_t;

   typedef enum logic [1:0] {
      CR_ACT  = 2'd0,
      CR_BASE = 2'd1,
      CR_OVR  = 2'd2,
      CR_NONE = 2'd3
   } creg_e;
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram
   import rxr_pkg::*;
#(
   parameter int NDESC = 8,
   localparam int IW = $clog2(NDESC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [IW-1:0]    host_idx,
   input  logic             host_word,
   input  logic [31:0]      host_wdata,
   output logic [31:0]      host_rdata,
   input  logic             eng_we,
   input  logic [IW-1:0]    eng_idx,
   input  logic [LEN_W-1:0] eng_st_in,
   input  logic [LEN_W-1:0] eng_len_in,
   output logic [LEN_W-1:0] eng_st,
   output logic [31:0]      eng_buf
);
   desc_t mem_q [NDESC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NDESC; i++) mem_q[i] <= '0;
      end else begin
         if (host_we) begin
            if (host_word) mem_q[host_idx].buf_addr <= host_wdata;
            else begin
               mem_q[host_idx].st  <= host_wdata[31:16];
               mem_q[host_idx].len <= host_wdata[15:0];
            end
         end
         // engine write-back wins over a host write to the same word
         if (eng_we) begin
            mem_q[eng_idx].st  <= eng_st_in;
            mem_q[eng_idx].len <= eng_len_in;
         end
      end
   end

   assign host_rdata = host_word ? mem_q[host_idx].buf_addr
                                 : {mem_q[host_idx].st, mem_q[host_idx].len};
   assign eng_st  = mem_q[eng_idx].st;
   assign eng_buf = mem_q[eng_idx].buf_addr;
endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
   import rxr_pkg::*;
#(
   parameter int IW    = 3,
   parameter int OVR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_we,
   input  logic             act_arm,
   input  logic             base_we,
   input  logic [IW-1:0]    base_val,
   input  logic             rearm,
   input  logic             drop,
   input  creg_e            sel,
   output logic             poll,
   output logic [IW-1:0]    base_idx,
   output logic [31:0]      rdata
);
   logic             poll_q;
   logic [IW-1:0]    base_q;
   logic [OVR_W-1:0] ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_q <= 1'b0;
         base_q <= '0;
         ovr_q  <= '0;
      end else begin
         if ((act_we && act_arm) || rearm) poll_q <= 1'b1;
         else if (drop)                    poll_q <= 1'b0;
         if (base_we) base_q <= base_val;
         if (drop)    ovr_q  <= ovr_q + 1'b1;
      end
   end

   always_comb begin
      case (sel)
         CR_ACT:  rdata = 32'(poll_q) << ACT_BIT;
         CR_BASE: rdata = 32'({base_q, 3'b000});
         CR_OVR:  rdata = 32'(ovr_q);
         default: rdata = '0;
      endcase
   end

   assign poll     = poll_q;
   assign base_idx = base_q;

   // R3 R8
   arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(poll_q) |-> $past((act_we && act_arm) || rearm));
   // R7
   disarm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(poll_q) |-> $past(drop));
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
   import rxr_pkg::*;
#(
   parameter int NDESC     = 8,
   parameter int BUF_MAX   = 1520,
   parameter int FRAME_MAX = 1518,
   localparam int IW = $clog2(NDESC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic             in_err,
   input  logic [7:0]       in_data,
   input  logic             poll,
   input  logic [IW-1:0]    base_idx,
   input  logic             base_wr,
   input  logic [LEN_W-1:0] cur_st,
   input  logic [31:0]      cur_buf,
   output logic [IW-1:0]    ent_idx,
   output logic             wb_we,
   output logic [LEN_W-1:0] wb_st,
   output logic [LEN_W-1:0] wb_len,
   output logic             drop,
   output logic             mem_we,
   output logic [31:0]      mem_addr,
   output logic [7:0]       mem_wdata
);
   localparam logic [LEN_W-1:0] BUF_LIM   = LEN_W'(BUF_MAX);
   localparam logic [LEN_W-1:0] FRAME_LIM = LEN_W'(FRAME_MAX);

   logic             busy_q, drop_q, err_q;
   logic [LEN_W-1:0] cnt_q, mem_off_q;
   logic [31:0]      bufa_q, mem_addr_q;
   logic [IW-1:0]    idx_q, idx_inc;
   logic             mem_we_q;
   logic [7:0]       mem_wdata_q;

   generate
      if ((NDESC & (NDESC - 1)) == 0) begin : g_pow2
         assign ent_idx = base_idx + idx_q;
         assign idx_inc = idx_q + 1'b1;
      end else begin : g_any
         localparam logic [IW:0]   ND_W     = (IW+1)'(NDESC);
         localparam logic [IW-1:0] LAST_IDX = IW'(NDESC - 1);
         logic [IW:0] sum;
         assign sum     = {1'b0, base_idx} + {1'b0, idx_q};
         assign ent_idx = (sum >= ND_W) ? IW'(sum - ND_W) : sum[IW-1:0];
         assign idx_inc = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   logic             start, ok, take, err_c, store, long_c;
   logic [LEN_W-1:0] cnt_c, cnt_n;
   logic [31:0]      addr_c;

   assign start  = in_valid && in_sof && !busy_q && !drop_q;
   assign ok     = poll && cur_st[ST_EMPTY];
   assign take   = in_valid && (start ? ok : busy_q);
   assign cnt_c  = start ? '0 : cnt_q;
   assign addr_c = start ? cur_buf : bufa_q;
   assign err_c  = (start ? 1'b0 : err_q) | in_err;
   assign store  = take && (cnt_c < BUF_LIM);
   assign cnt_n  = (cnt_c == '1) ? cnt_c : cnt_c + 1'b1;
   assign long_c = cnt_n > FRAME_LIM;
   assign drop   = start && !ok;
   assign wb_we  = take && in_eof;
   assign wb_len = (cnt_n > BUF_LIM) ? BUF_LIM : cnt_n;

   always_comb begin
      wb_st                 = cur_st;
      wb_st[ST_EMPTY]       = 1'b0;
      wb_st[ERR_BITS-1:0]   = '0;
      wb_st[ST_LONG]        = long_c;
      wb_st[ST_RXERR]       = err_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         drop_q      <= 1'b0;
         err_q       <= 1'b0;
         cnt_q       <= '0;
         bufa_q      <= '0;
         idx_q       <= '0;
         mem_we_q    <= 1'b0;
         mem_addr_q  <= '0;
         mem_wdata_q <= '0;
         mem_off_q   <= '0;
      end else begin
         if (wb_we)             busy_q <= 1'b0;
         else if (start && ok)  busy_q <= 1'b1;
         if (drop && !in_eof)                     drop_q <= 1'b1;
         else if (drop_q && in_valid && in_eof)   drop_q <= 1'b0;
         if (take) begin
            cnt_q  <= cnt_n;
            bufa_q <= addr_c;
            err_q  <= err_c;
         end
         if (base_wr)    idx_q <= '0;
         else if (wb_we) idx_q <= cur_st[ST_WRAP] ? '0 : idx_inc;
         mem_we_q    <= store;
         mem_addr_q  <= addr_c + 32'(cnt_c);
         mem_wdata_q <= in_data;
         mem_off_q   <= cnt_c;
      end
   end

   assign mem_we    = mem_we_q;
   assign mem_addr  = mem_addr_q;
   assign mem_wdata = mem_wdata_q;

   // R4
   write_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_q |-> $past(in_valid));
   // R7
   dropped_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_q && in_valid) |=> !mem_we_q);
   // R9
   within_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_q |-> (mem_off_q < BUF_LIM));
   // R6
   wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_we && cur_st[ST_WRAP] && !base_wr) |=> (ent_idx == base_idx));
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
   import rxr_pkg::*;
#(
   parameter int NDESC     = 8,
   parameter int BUF_MAX   = 1520,
   parameter int FRAME_MAX = 1518,
   parameter int OVR_W     = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      host_wr,
   input  logic [$clog2(NDESC)+3:0]  host_addr,
   input  logic [31:0]               host_wdata,
   output logic [31:0]               host_rdata,
   input  logic                      in_valid,
   input  logic                      in_sof,
   input  logic                      in_eof,
   input  logic                      in_err,
   input  logic [7:0]                in_data,
   output logic                      mem_we,
   output logic [31:0]               mem_addr,
   output logic [7:0]                mem_wdata
);
   localparam int IW  = $clog2(NDESC);
   localparam int HAW = IW + 4;

   generate
      if (NDESC < 2) begin : g_bad_ndesc
         $error("NDESC must be at least 2");
      end
      if (FRAME_MAX > BUF_MAX) begin : g_bad_frame
         $error("FRAME_MAX must not exceed BUF_MAX");
      end
      if (BUF_MAX >= (1 << LEN_W) - 1) begin : g_bad_buf
         $error("BUF_MAX must fit the length field");
      end
   endgenerate

   logic          is_ctrl, is_word1;
   logic [IW-1:0] hidx;
   creg_e         csel;
   logic          unused_lsb;

   assign is_ctrl    = host_addr[HAW-1];
   assign is_word1   = host_addr[2];
   assign hidx       = host_addr[HAW-2:3];
   assign csel       = creg_e'(host_addr[3:2]);
   assign unused_lsb = ^host_addr[1:0];

   logic             poll, base_wr, rearm, drop, wb_we;
   logic [IW-1:0]    base_idx, ent_idx;
   logic [LEN_W-1:0] cur_st, wb_st, wb_len;
   logic [31:0]      cur_buf, ram_rdata, reg_rdata;

   assign base_wr = host_wr && is_ctrl && (csel == CR_BASE);
   assign rearm   = host_wr && !is_ctrl && !is_word1 && host_wdata[31];

   rxr_desc_ram #(.NDESC(NDESC)) u_ram (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_wr && !is_ctrl),
      .host_idx   (hidx),
      .host_word  (is_word1),
      .host_wdata (host_wdata),
      .host_rdata (ram_rdata),
      .eng_we     (wb_we),
      .eng_idx    (ent_idx),
      .eng_st_in  (wb_st),
      .eng_len_in (wb_len),
      .eng_st     (cur_st),
      .eng_buf    (cur_buf)
   );

   rxr_regs #(.IW(IW), .OVR_W(OVR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_we   (host_wr && is_ctrl && (csel == CR_ACT)),
      .act_arm  (host_wdata[ACT_BIT]),
      .base_we  (base_wr),
      .base_val (host_wdata[IW+2:3]),
      .rearm    (rearm),
      .drop     (drop),
      .sel      (csel),
      .poll     (poll),
      .base_idx (base_idx),
      .rdata    (reg_rdata)
   );

   rxr_engine #(.NDESC(NDESC), .BUF_MAX(BUF_MAX), .FRAME_MAX(FRAME_MAX)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .in_err    (in_err),
      .in_data   (in_data),
      .poll      (poll),
      .base_idx  (base_idx),
      .base_wr   (base_wr),
      .cur_st    (cur_st),
      .cur_buf   (cur_buf),
      .ent_idx   (ent_idx),
      .wb_we     (wb_we),
      .wb_st     (wb_st),
      .wb_len    (wb_len),
      .drop      (drop),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   assign host_rdata = is_ctrl ? reg_rdata : ram_rdata;
endmodule

// File: tb/rx_ring_mgr_tb.sv
module rx_ring_mgr_tb;
   localparam int ND = 4;
   localparam int BM = 20;
   localparam int FM = 18;
   localparam logic [5:0] A_ACT  = 6'h20;
   localparam logic [5:0] A_BASE = 6'h24;
   localparam logic [5:0] A_OVR  = 6'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [5:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
   logic [7:0]  in_data = '0;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rx_ring_mgr #(.NDESC(ND), .BUF_MAX(BM), .FRAME_MAX(FM)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
      .in_data(in_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

   // behavioural reference state
   logic [15:0] m_st [ND];
   logic [15:0] m_len [ND];
   logic [31:0] m_ba [ND];
   bit          m_poll, m_busy, m_drop, m_err;
   int          m_base, m_idx, m_ovr, m_cnt;
   logic [31:0] m_cur;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic step(logic v, logic s, logic e, logic er, logic [7:0] d, string req);
      int          ent;
      bit          exp_we;
      logic [31:0] exp_addr;
      logic [15:0] st;
      in_valid = v; in_sof = s; in_eof = e; in_err = er; in_data = d;
      ent = (m_base + m_idx) % ND;
      exp_we = 0; exp_addr = '0;
      if (v) begin
         if (s && !m_busy && !m_drop) begin
            if (m_poll && m_st[ent][15]) begin
               m_busy = 1; m_cnt = 0; m_cur = m_ba[ent]; m_err = 0;
            end else begin
               m_ovr++; m_poll = 0; m_drop = !e;
            end
         end else if (m_drop && e) m_drop = 0;
         if (m_busy) begin
            m_err = m_err | er;
            if (m_cnt < BM) begin exp_we = 1; exp_addr = m_cur + 32'(m_cnt); end
            m_cnt++;
            if (e) begin
               st = m_st[ent];
               st[15] = 1'b0; st[5:0] = '0;
               st[5] = (m_cnt > FM); st[1] = m_err;
               m_len[ent] = 16'((m_cnt > BM) ? BM : m_cnt);
               m_idx = m_st[ent][13] ? 0 : (m_idx + 1) % ND;
               m_st[ent] = st;
               m_busy = 0;
            end
         end
      end
      @(negedge clk);
      chk({req, " mem_we"}, 32'(mem_we), 32'(exp_we));
      if (exp_we && mem_we) begin
         chk({req, " mem_addr"}, mem_addr, exp_addr);
         chk({req, " mem_wdata"}, 32'(mem_wdata), 32'(d));
      end
   endtask

   task automatic send_frame(int n, int err_at, int seed, string req);
      for (int k = 0; k < n; k++)
         step(1'b1, k == 0, k == n - 1, k == err_at, 8'((seed * 13 + k * 7) & 255), req);
      step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, req);
   endtask

   task automatic host_write(logic [5:0] a, logic [31:0] d);
      int e;
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      if (a[5]) begin
         case (a[3:2])
            2'd0: if (d[24]) m_poll = 1;
            2'd1: begin m_base = int'(d[4:3]); m_idx = 0; end
            default: ;
         endcase
      end else begin
         e = int'(a[4:3]);
         if (a[2]) m_ba[e] = d;
         else begin
            m_st[e] = d[31:16]; m_len[e] = d[15:0];
            if (d[31]) m_poll = 1;
         end
      end
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(logic [5:0] a, string req);
      logic [31:0] exp;
      int e;
      host_addr = a;
      #1;
      if (a[5]) begin
         case (a[3:2])
            2'd0: exp = m_poll ? 32'h0100_0000 : 32'h0;
            2'd1: exp = 32'(m_base * 8);
            2'd2: exp = 32'(m_ovr);
            default: exp = 32'h0;
         endcase
      end else begin
         e = int'(a[4:3]);
         exp = a[2] ? m_ba[e] : {m_st[e], m_len[e]};
      end
      chk(req, host_rdata, exp);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < ND; i++) begin m_st[i] = '0; m_len[i] = '0; m_ba[i] = '0; end
      m_poll = 0; m_busy = 0; m_drop = 0; m_err = 0;
      m_base = 0; m_idx = 0; m_ovr = 0; m_cnt = 0; m_cur = '0;
      repeat (3) @(negedge clk);
      chk("R1 mem_we in reset", 32'(mem_we), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      host_read(A_ACT,  "R1 act");
      host_read(A_BASE, "R1 base");
      host_read(A_OVR,  "R1 ovr");
      for (int i = 0; i < ND; i++) begin
         host_read(6'(i * 8),     "R1 desc w0");
         host_read(6'(i * 8 + 4), "R1 desc w1");
      end
      step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R1");
      // R7 frame with polling never armed
      send_frame(3, -1, 1, "R7");
      host_read(A_OVR, "R7 ovr after unarmed");
      // R2 buffer addresses and R8 non-arming word
      for (int i = 0; i < ND; i++) host_write(6'(i * 8 + 4), 32'h1000 + 32'(i * 256));
      for (int i = 0; i < ND; i++) host_read(6'(i * 8 + 4), "R2 buffer addr");
      host_read(A_ACT, "R8 word1 no arm");
      // R3 activation
      host_write(A_ACT, 32'h0000_0000);
      host_read(A_ACT, "R3 no bit24");
      host_write(A_ACT, 32'h0100_0000);
      host_read(A_ACT, "R3 armed");
      // R7 armed but descriptor not empty
      send_frame(4, -1, 2, "R7");
      host_read(A_ACT, "R7 disarmed");
      host_read(A_OVR, "R7 ovr");
      // R8 hand descriptors to the block
      for (int i = 0; i < ND; i++)
         host_write(6'(i * 8), (i == ND - 1) ? 32'hA000_0000 : 32'h8000_0000);
      host_read(A_ACT, "R8 rearm");
      host_read(6'(24), "R2 desc3 w0");
      // R12 stray bytes
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h55, "R12");
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'h66, "R12");
      step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R12");
      host_read(6'(0), "R12 desc0 untouched");
      // R4 R5 normal frame
      send_frame(6, -1, 3, "R4");
      host_read(6'(0), "R5 desc0 writeback");
      // R10 single byte with error
      send_frame(1, 0, 4, "R10");
      host_read(6'(8), "R10 desc1 writeback");
      // R9 long truncated frame, then exactly FRAME_MAX
      send_frame(25, -1, 5, "R9");
      host_read(6'(16), "R9 desc2 long");
      send_frame(FM, 3, 6, "R9");
      host_read(6'(24), "R9 R5 desc3 exact max with wrap");
      // R6 wrap returns to desc0, still owned by host
      send_frame(5, -1, 7, "R6");
      host_read(A_OVR, "R6 ovr after wrap");
      host_read(A_ACT, "R6 disarmed");
      host_write(6'(0), 32'h8000_0000);
      send_frame(FM + 1, -1, 8, "R6");
      host_read(6'(0), "R6 R9 desc0 reused");
      // R11 base moves to entry 2
      host_write(A_BASE, 32'h0000_0010);
      host_read(A_BASE, "R11 base");
      host_write(6'(16), 32'h8000_0000);
      host_write(6'(24), 32'hA000_0000);
      send_frame(4, -1, 9, "R11");
      host_read(6'(16), "R11 desc2");
      send_frame(5, 2, 10, "R11");
      host_read(6'(24), "R11 desc3");
      host_write(6'(16), 32'h8000_0000);
      send_frame(3, -1, 11, "R11");
      host_read(6'(16), "R11 R6 wrap to base");
      host_read(A_OVR, "R7 ovr final");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule